// File: doc/BRIEF.md
# Frame-Synchronised Masked Register Updater

This block keeps a short list of pending register updates and lays them onto a target register file at a frame boundary, so that a display pipeline never runs a frame with only part of a new configuration applied. Each slot of the list holds a target offset, a mask and a value. A host fills the slots, then arms the list. The list is normally deferred until the next frame-done event. For a full mode change it is applied at once.

A sequencer walks the slots in index order. A slot with a zero mask becomes one plain write. A slot with a non-zero mask becomes a read of the target register followed by a merged write. The walk stops at the first slot whose offset is all ones, or after the last slot. When the walk finishes, the pending flag and the frame-done enable drop and a one-cycle completion pulse is raised. The block also passes the vertical-sync notification on only while no update is pending.

The sequencer has five states:
- `ST_IDLE` waits for a start.
- `ST_DECIDE` inspects the current slot. It goes to `ST_FINISH` on the terminator, to `ST_WRITE` for a zero mask, and to `ST_READ` otherwise.
- `ST_READ` captures the old content and always moves to `ST_WRITE`.
- `ST_WRITE` goes to `ST_FINISH` after the last slot, and otherwise back to `ST_DECIDE` with the next index.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `frame_reg_updater`

## Requirements
- R1: Slots are processed in ascending index order. The walk ends at the first slot whose offset is all ones, and no slot after it is touched. A walk with no terminator ends after slot DEPTH. After reset every slot holds the all-ones offset, so a walk of an untouched list makes no access.
- R2: A slot with mask zero produces exactly one write cycle (`tgt_wr_en` high), with `tgt_wdata` equal to the slot value and no read before it.
- R3: A slot with a non-zero mask produces one read cycle (`tgt_rd_en` high), then one write cycle carrying (old content AND mask) OR value.
- R4: `arm_req` sets `pending`. The walk then starts only after a `frame_done` pulse seen while `pending` is set. At the end of the walk `done` is high for exactly one cycle and `pending` is low from the next cycle. A later `frame_done` without a new arm starts nothing.
- R5: `vblank_evt` is high in the cycle after a `vsync` pulse only if `pending` was low when `vsync` was sampled.
- R6: `arm_now` taken while idle starts the walk in the next cycle, without any `frame_done`.
- R7: A `frame_done` seen before or in the same cycle as an accepted `arm_req` is discarded when arming, and does not start the walk.
- R8: While `busy` is high, `arm_req`, `arm_now` and `ld_en` are ignored. They change neither the queue contents nor `pending`, and start no further walk.
- R9: After reset, `pending`, `busy`, `done`, `vblank_evt`, `tgt_rd_en` and `tgt_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load one queue slot |
| ld_slot | input | IDX_W | Slot index to load (0..DEPTH) |
| ld_offset | input | ADDR_W | Target offset; all ones marks the terminator |
| ld_mask | input | DATA_W | Keep-mask; zero selects a plain write |
| ld_value | input | DATA_W | Value written or ORed in |
| arm_req | input | 1 | Arm the list for the next frame-done |
| arm_now | input | 1 | Apply the list at once (full mode change) |
| frame_done | input | 1 | Frame-done event pulse |
| vsync | input | 1 | Vertical sync event pulse |
| tgt_rdata | input | DATA_W | Read data of the target register at `tgt_addr`, same cycle |
| tgt_rd_en | output | 1 | Target read strobe |
| tgt_wr_en | output | 1 | Target write strobe |
| tgt_addr | output | ADDR_W | Target register offset |
| tgt_wdata | output | DATA_W | Target write data |
| pending | output | 1 | A deferred update is armed and not yet applied |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| vblank_evt | output | 1 | Gated vertical-sync notification |

## Verification
The bench drives a list that mixes plain writes and read-modify-writes, including a merge into a register that an earlier slot of the same list has just written. This separates in-order application from any reordering. The same walk run with a terminator in the middle shows that slots past the terminator are left alone. A list filled to every slot without a terminator exercises the end-of-storage stop. A stale frame-done before arming, a vsync while pending and a vsync while idle, and arm and load attempts during a walk tell correct deferral and gating apart from an early trigger, a missing gate or a walk that can be disturbed. Every target write is compared, as it happens, with a behavioural model built from queues.

// File: rtl/frupd_pkg.sv
package frupd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/frupd_queue.sv
module frupd_queue #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SLOTS  = 17,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_mask,
    output logic [DATA_W-1:0] rd_val
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    logic [ADDR_W-1:0] off_q  [SLOTS];
    logic [DATA_W-1:0] mask_q [SLOTS];
    logic [DATA_W-1:0] val_q  [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q[g]  <= '1;
                mask_q[g] <= '0;
                val_q[g]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                off_q[g]  <= wr_off;
                mask_q[g] <= wr_mask;
                val_q[g]  <= wr_val;
            end
        end
    end

    always_comb begin
        if (rd_idx <= LAST_IDX) begin
            rd_off  = off_q[rd_idx];
            rd_mask = mask_q[rd_idx];
            rd_val  = val_q[rd_idx];
        end else begin
            rd_off  = '1;
            rd_mask = '0;
            rd_val  = '0;
        end
    end

endmodule

// File: rtl/frupd_seq.sv
module frupd_seq
    import frupd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int SLOTS  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ent_off,
    input  logic [DATA_W-1:0] ent_mask,
    input  logic [DATA_W-1:0] ent_val,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              tgt_rd_en,
    output logic              tgt_wr_en,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              busy,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    seq_state_t        st, nxt;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] old_q;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (start) nxt = ST_DECIDE;
            ST_DECIDE: begin
                if (ent_off == '1)        nxt = ST_FINISH;
                else if (ent_mask == '0)  nxt = ST_WRITE;
                else                      nxt = ST_READ;
            end
            ST_READ:   nxt = ST_WRITE;
            ST_WRITE:  nxt = (idx_q == LAST_IDX) ? ST_FINISH : ST_DECIDE;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            old_q <= '0;
        end else begin
            if (st == ST_IDLE && start)
                idx_q <= '0;
            else if (st == ST_WRITE && idx_q != LAST_IDX)
                idx_q <= idx_q + 1'b1;
            if (st == ST_READ)
                old_q <= tgt_rdata;
        end
    end

    always_comb begin
        cur_idx   = idx_q;
        tgt_addr  = ent_off;
        tgt_rd_en = (st == ST_READ);
        tgt_wr_en = (st == ST_WRITE);
        tgt_wdata = (ent_mask == '0) ? ent_val : ((old_q & ent_mask) | ent_val);
        busy      = (st != ST_IDLE);
        done      = (st == ST_FINISH);
    end

    AST_RMW_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_en && ent_mask != '0) |-> $past(tgt_rd_en)); // R3
    AST_PLAIN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_en && ent_mask == '0) |-> !$past(tgt_rd_en)); // R2
    AST_NO_SENTINEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_en || tgt_rd_en) |-> (tgt_addr != '1)); // R1
    AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R4

endmodule

// File: rtl/frupd_trig.sv
module frupd_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_acc,
    input  logic frame_done,
    input  logic walk_busy,
    input  logic walk_done,
    input  logic vsync,
    output logic pending,
    output logic start_def,
    output logic vblank_evt
);

    logic fd_seen;

    assign start_def = pending && fd_seen && !walk_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            fd_seen    <= 1'b0;
            vblank_evt <= 1'b0;
        end else begin
            if (walk_done)    pending <= 1'b0;
            else if (arm_acc) pending <= 1'b1;

            if (arm_acc)         fd_seen <= 1'b0;
            else if (start_def)  fd_seen <= 1'b0;
            else if (frame_done) fd_seen <= 1'b1;

            vblank_evt <= vsync && !pending;
        end
    end

    AST_STALE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        arm_acc |=> !fd_seen); // R7
    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !pending); // R4

endmodule

// File: rtl/frame_reg_updater.sv
module frame_reg_updater #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int SLOTS = DEPTH + 1,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_slot,
    input  logic [ADDR_W-1:0] ld_offset,
    input  logic [DATA_W-1:0] ld_mask,
    input  logic [DATA_W-1:0] ld_value,
    input  logic              arm_req,
    input  logic              arm_now,
    input  logic              frame_done,
    input  logic              vsync,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              tgt_rd_en,
    output logic              tgt_wr_en,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              pending,
    output logic              busy,
    output logic              done,
    output logic              vblank_evt
);

    logic              ld_acc, arm_acc, now_acc, start_def, start;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] ent_off;
    logic [DATA_W-1:0] ent_mask, ent_val;

    assign ld_acc  = ld_en   && !busy;
    assign arm_acc = arm_req && !busy;
    assign now_acc = arm_now && !busy;
    assign start   = now_acc || start_def;

    frupd_queue #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .IDX_W(IDX_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ld_acc), .wr_idx(ld_slot), .wr_off(ld_offset),
        .wr_mask(ld_mask), .wr_val(ld_value),
        .rd_idx(cur_idx), .rd_off(ent_off), .rd_mask(ent_mask), .rd_val(ent_val)
    );

    frupd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SLOTS(SLOTS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ent_off(ent_off), .ent_mask(ent_mask), .ent_val(ent_val),
        .tgt_rdata(tgt_rdata), .cur_idx(cur_idx),
        .tgt_rd_en(tgt_rd_en), .tgt_wr_en(tgt_wr_en),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .busy(busy), .done(done)
    );

    frupd_trig u_trig (
        .clk(clk), .rst_n(rst_n), .arm_acc(arm_acc),
        .frame_done(frame_done), .walk_busy(busy), .walk_done(done),
        .vsync(vsync), .pending(pending), .start_def(start_def),
        .vblank_evt(vblank_evt)
    );

    AST_VBLANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> !vblank_evt); // R5
    AST_WALK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(arm_now) || $past(pending))); // R6

endmodule

// File: tb/sim_frame_reg_updater.sv
module sim_frame_reg_updater;

    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int SLOTS = DEPTH + 1;
    localparam int IW    = $clog2(SLOTS);
    localparam int NREG  = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, ld_en, arm_req, arm_now, frame_done, vsync;
    logic [IW-1:0] ld_slot;
    logic [AW-1:0] ld_offset, tgt_addr;
    logic [DW-1:0] ld_mask, ld_value, tgt_rdata, tgt_wdata;
    logic          tgt_rd_en, tgt_wr_en, pending, busy, done, vblank_evt;

    frame_reg_updater #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_slot(ld_slot),
        .ld_offset(ld_offset), .ld_mask(ld_mask), .ld_value(ld_value),
        .arm_req(arm_req), .arm_now(arm_now), .frame_done(frame_done),
        .vsync(vsync), .tgt_rdata(tgt_rdata), .tgt_rd_en(tgt_rd_en),
        .tgt_wr_en(tgt_wr_en), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .pending(pending), .busy(busy), .done(done), .vblank_evt(vblank_evt)
    );

    logic [DW-1:0] tmem [NREG];
    logic [DW-1:0] rmem [NREG];
    logic [AW-1:0] q_off  [SLOTS];
    logic [DW-1:0] q_mask [SLOTS];
    logic [DW-1:0] q_val  [SLOTS];
    logic [AW+DW-1:0] expq [$];
    int checks = 0;
    int fails  = 0;

    assign tgt_rdata = tmem[tgt_addr];

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the write port against the model's expected stream (R1 R2 R3)
    always @(negedge clk) begin
        if (rst_n && tgt_wr_en) begin
            tmem[tgt_addr] <= tgt_wdata;
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R1: actual write %0h<=%0h expected no write", tgt_addr, tgt_wdata);
            end else begin
                logic [AW+DW-1:0] e;
                e = expq.pop_front();
                if ({tgt_addr, tgt_wdata} !== e) begin
                    fails++;
                    $display("FAIL R3: actual write %0h expected %0h", {tgt_addr, tgt_wdata}, e);
                end
            end
        end
    end

    task automatic model_walk();
        for (int i = 0; i < SLOTS; i++) begin
            logic [DW-1:0] nv;
            if (q_off[i] == '1) break;
            nv = (q_mask[i] == '0) ? q_val[i] : ((rmem[q_off[i]] & q_mask[i]) | q_val[i]);
            rmem[q_off[i]] = nv;
            expq.push_back({q_off[i], nv});
        end
    endtask

    task automatic load(int s, logic [AW-1:0] o, logic [DW-1:0] m, logic [DW-1:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_slot = IW'(s); ld_offset = o; ld_mask = m; ld_value = v;
        q_off[s] = o; q_mask[s] = m; q_val[s] = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = -1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        int bad;
        rst_n = 1'b0; ld_en = 1'b0; ld_slot = '0; ld_offset = '0; ld_mask = '0;
        ld_value = '0; arm_req = 1'b0; arm_now = 1'b0; frame_done = 1'b0; vsync = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            tmem[i] = (i * 32'h0101_0101) ^ 32'h5A3C_96E1;
            rmem[i] = tmem[i];
        end
        for (int i = 0; i < SLOTS; i++) begin
            q_off[i] = '1; q_mask[i] = '0; q_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 pending", pending, 0);
        chk("R9 busy", busy, 0);
        chk("R9 strobes", {tgt_rd_en, tgt_wr_en, done, vblank_evt}, 0);

        // R6 immediate walk; R1 untouched list holds only terminators
        model_walk();
        @(negedge clk); arm_now = 1'b1;
        @(negedge clk); arm_now = 1'b0;
        chk("R6 busy after arm_now", busy, 1);
        wait_done(cyc);
        chk("R1 empty walk ends", (cyc >= 0), 1);

        // Mixed list with a terminator in the middle
        load(0, 8'h03, 32'h0,         32'hA5A5_3C01);
        load(1, 8'h05, 32'hFFFF_0000, 32'h0000_1234);
        load(2, 8'h03, 32'h0000_FF00, 32'h0000_0050);
        load(3, 8'hFF, 32'h0,         32'h0);
        load(4, 8'h09, 32'h0,         32'h0000_DEAD);

        // R7 stale frame_done before arming
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0; arm_req = 1'b1;
        @(negedge clk); arm_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 stale frame_done no walk", busy, 0);
        chk("R4 pending after arm", pending, 1);

        // R5 vsync while pending
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        chk("R5 vblank gated", vblank_evt, 0);

        // R4 frame_done triggers the deferred walk
        model_walk();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        @(negedge clk);
        chk("R4 walk started", busy, 1);
        // R8 ignored operations during the walk
        arm_now = 1'b1; arm_req = 1'b1;
        ld_en = 1'b1; ld_slot = '0; ld_offset = 8'h03; ld_mask = '0; ld_value = 32'h1111_1111;
        @(negedge clk);
        arm_now = 1'b0; arm_req = 1'b0; ld_en = 1'b0;
        if (!done) wait_done(cyc); else cyc = 0;
        chk("R4 done seen", (cyc >= 0), 1);
        @(negedge clk);
        chk("R4 done one cycle", done, 0);
        chk("R4 pending cleared", pending, 0);
        repeat (3) @(negedge clk);
        chk("R8 no walk from ignored arm", busy, 0);
        chk("R8 pending unchanged", pending, 0);
        chk("R1 slot after terminator untouched", tmem[9], rmem[9]);
        chk("R3 merge on rewritten reg", tmem[3], 32'h0000_3C50);

        // R4 frame_done after use starts nothing
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 no walk without re-arm", busy, 0);

        // R5 vsync while idle passes
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        chk("R5 vblank passes", vblank_evt, 1);

        // R8 load during walk was ignored: same list replays
        model_walk();
        @(negedge clk); arm_now = 1'b1;
        @(negedge clk); arm_now = 1'b0;
        wait_done(cyc);
        chk("R8 replay done", (cyc >= 0), 1);

        // R1 full storage with no terminator, R2/R3 mixed
        for (int i = 0; i < SLOTS; i++)
            load(i, AW'(16 + i), (i % 2 == 0) ? 32'h0 : 32'h00FF_00FF, i * 32'h0102_0304);
        model_walk();
        @(negedge clk); arm_now = 1'b1;
        @(negedge clk); arm_now = 1'b0;
        wait_done(cyc);
        chk("R1 full list ends", (cyc >= 0), 1);
        repeat (2) @(negedge clk);

        chk("R1 all expected writes seen", expq.size(), 0);
        bad = 0;
        for (int i = 0; i < NREG; i++)
            if (tmem[i] !== rmem[i]) bad++;
        chk("R3 register file matches model", bad, 0);

        summary();
        $finish;
    end

endmodule